// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block takes a three-wire serial programming stream (a data line, a shift clock and a load strobe) and turns it into the divide settings of a frequency synthesizer. All three wires are treated as slow asynchronous inputs. They are resynchronized into a fast system clock, and the block acts on the rising edges it detects there. Each detected rising edge of the shift clock moves one data bit into a shift register, most significant bit first.

Every word ends in a routing bit. When the load strobe rises, the routing bit picks one of two targets. A one sends the word to the reference target: a prescaler mode bit and a 14-bit reference ratio, 16 bits in all. A zero sends it to the main divider target: an 11-bit N count followed by a 7-bit swallow count A, 19 bits in all. A word whose ratio falls in the prohibited range is dropped. The target keeps its old contents and a sticky error flag is raised.

Top module: `sl_top`

## Requirements
- R1: While `rst` is high and after it falls, until a load is accepted, the outputs show `ref_ratio`=8, `n_val`=16, `a_val`=0, `psc_sel`=0 and `cfg_err`=0.
- R2: Each rising edge of `ser_clk` shifts the current `ser_data` value into the shift register. Words are sent most significant bit first, and the routing bit is always the last bit sent.
- R3: A word with routing bit 1 is laid out as {mode bit, R[13:0], 1}. On a rising edge of `ser_le` it updates `psc_sel` and `ref_ratio`, and leaves `n_val` and `a_val` unchanged.
- R4: A word with routing bit 0 is laid out as {N[10:0], A[6:0], 0}. On a rising edge of `ser_le` it updates `n_val` and `a_val`, and leaves `psc_sel` and `ref_ratio` unchanged.
- R5: `psc_sel`=0 selects the divide-by-128/129 prescaler mode and `psc_sel`=1 selects the divide-by-64/65 mode. The output equals the mode bit of the last accepted reference word.
- R6: A reference word with R below 8 is rejected. `psc_sel` and `ref_ratio` keep their old values and `cfg_err` becomes 1. Any R from 8 to 16383 is accepted.
- R7: A main word with N below 16 is rejected. `n_val` and `a_val` keep their old values and `cfg_err` becomes 1. Any N from 16 to 2047 with any A from 0 to 127 is accepted.
- R8: `cfg_err` stays at 1 until the next accepted word of either kind clears it to 0.
- R9: A word is transferred only once, on the rising edge of `ser_le`. Further `ser_clk` edges while `ser_le` stays high change no output.
- R10: `ser_clk` activity while `ser_le` is low changes no output.
- R11: Bits shifted in before the last 16 (reference word) or the last 19 (main word) have no effect on the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| psc_sel | output | 1 | Prescaler mode, 0 = 128/129, 1 = 64/65 |
| ref_ratio | output | 14 | Reference divide ratio |
| n_val | output | 11 | Main counter N value |
| a_val | output | 7 | Swallow counter A value |
| cfg_err | output | 1 | Sticky error flag for a rejected word |

## Verification
The bench sweeps the reference ratio upward from zero across the accept limit at 8, and sweeps N across its limit at 16 with a varying A. These sweeps separate an off-by-one in either range check and show that rejected words keep the old contents. Walking-one ratio and N/A patterns check every field bit position and show that the two targets do not disturb each other. Further stimuli check the special cases. The load strobe is held high while more shift clocks arrive. Shifting happens with no load at all. A reference word is sent behind junk leading bits. A failing word is followed by a good one to check that the error flag clears.

// File: rtl/sl_pkg.sv
package sl_pkg;
  // Routing bit value carried in the last bit of every word
  typedef enum logic {
    ROUTE_MAIN = 1'b0,
    ROUTE_REF  = 1'b1
  } route_e;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sl_rise.sv
module sl_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/sl_shift.sv
module sl_shift #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/sl_decode.sv
module sl_decode #(
  parameter int R_W   = 14,
  parameter int N_W   = 11,
  parameter int A_W   = 7,
  parameter int SH_W  = 19,
  parameter int R_MIN = 8,
  parameter int N_MIN = 16
) (
  input  logic [SH_W-1:0] word,
  output sl_pkg::route_e  route,
  output logic            psc,
  output logic [R_W-1:0]  r,
  output logic [N_W-1:0]  n,
  output logic [A_W-1:0]  a,
  output logic            r_ok,
  output logic            n_ok
);
  // Reference layout: {psc, r, route}; main layout: {n, a, route}
  assign route = sl_pkg::route_e'(word[0]);
  assign r     = word[R_W:1];
  assign psc   = word[R_W+1];
  assign a     = word[A_W:1];
  assign n     = word[A_W+N_W:A_W+1];
  assign r_ok  = ({18'd0, r} >= R_MIN[R_W+17:0]);
  assign n_ok  = ({21'd0, n} >= N_MIN[N_W+20:0]);
endmodule

// File: rtl/sl_top.sv
module sl_top #(
  parameter int R_W    = 14,
  parameter int N_W    = 11,
  parameter int A_W    = 7,
  parameter int SYNC   = 2,
  parameter int R_MIN  = 8,
  parameter int N_MIN  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_le,
  output logic           psc_sel,
  output logic [R_W-1:0] ref_ratio,
  output logic [N_W-1:0] n_val,
  output logic [A_W-1:0] a_val,
  output logic           cfg_err
);
  localparam int REF_LEN  = R_W + 2;
  localparam int MAIN_LEN = N_W + A_W + 1;
  localparam int SH_W     = (REF_LEN > MAIN_LEN) ? REF_LEN : MAIN_LEN;

  logic clk_s, data_s, le_s;
  logic clk_rise, le_rise;
  logic [SH_W-1:0] word;

  sl_sync #(.STAGES(SYNC)) sync_clk_i  (.clk(clk), .rst(rst), .din(ser_clk),  .dout(clk_s));
  sl_sync #(.STAGES(SYNC)) sync_data_i (.clk(clk), .rst(rst), .din(ser_data), .dout(data_s));
  sl_sync #(.STAGES(SYNC)) sync_le_i   (.clk(clk), .rst(rst), .din(ser_le),   .dout(le_s));

  sl_rise rise_clk_i (.clk(clk), .rst(rst), .lvl(clk_s), .rise(clk_rise));
  sl_rise rise_le_i  (.clk(clk), .rst(rst), .lvl(le_s),  .rise(le_rise));

  sl_shift #(.W(SH_W)) shift_i (
    .clk(clk), .rst(rst), .en(clk_rise), .din(data_s), .q(word)
  );

  sl_pkg::route_e  d_route;
  logic            d_psc, d_r_ok, d_n_ok;
  logic [R_W-1:0]  d_r;
  logic [N_W-1:0]  d_n;
  logic [A_W-1:0]  d_a;

  sl_decode #(
    .R_W(R_W), .N_W(N_W), .A_W(A_W), .SH_W(SH_W), .R_MIN(R_MIN), .N_MIN(N_MIN)
  ) dec_i (
    .word(word), .route(d_route), .psc(d_psc), .r(d_r), .n(d_n), .a(d_a),
    .r_ok(d_r_ok), .n_ok(d_n_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_sel   <= 1'b0;
      ref_ratio <= R_W'(R_MIN);
      n_val     <= N_W'(N_MIN);
      a_val     <= '0;
      cfg_err   <= 1'b0;
    end else if (le_rise) begin
      if (d_route == sl_pkg::ROUTE_REF) begin
        if (d_r_ok) begin
          psc_sel   <= d_psc;
          ref_ratio <= d_r;
          cfg_err   <= 1'b0;
        end else begin
          cfg_err   <= 1'b1;
        end
      end else begin
        if (d_n_ok) begin
          n_val   <= d_n;
          a_val   <= d_a;
          cfg_err <= 1'b0;
        end else begin
          cfg_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sl_chk.sv
module sl_chk #(
  parameter int R_W   = 14,
  parameter int N_W   = 11,
  parameter int A_W   = 7,
  parameter int R_MIN = 8,
  parameter int N_MIN = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           le_rise,
  input logic           psc_sel,
  input logic [R_W-1:0] ref_ratio,
  input logic [N_W-1:0] n_val,
  input logic [A_W-1:0] a_val,
  input logic           cfg_err
);
  // R1
  reset_vals_chk: assert property (@(posedge clk)
    rst |=> (ref_ratio == R_W'(R_MIN) && n_val == N_W'(N_MIN) && a_val == '0
             && !psc_sel && !cfg_err));

  // R6
  ref_min_chk: assert property (@(posedge clk) disable iff (rst)
    {18'd0, ref_ratio} >= R_MIN[R_W+17:0]);

  // R7
  n_min_chk: assert property (@(posedge clk) disable iff (rst)
    {21'd0, n_val} >= N_MIN[N_W+20:0]);

  // R8
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> ($stable(ref_ratio) && $stable(n_val) && $stable(a_val)
                        && $stable(psc_sel)));

  // R9
  only_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    !le_rise |=> ($stable(ref_ratio) && $stable(n_val) && $stable(a_val)
                  && $stable(psc_sel) && $stable(cfg_err)));
endmodule

bind sl_top sl_chk #(
  .R_W(R_W), .N_W(N_W), .A_W(A_W), .R_MIN(R_MIN), .N_MIN(N_MIN)
) chk_i (
  .clk(clk), .rst(rst), .le_rise(le_rise), .psc_sel(psc_sel),
  .ref_ratio(ref_ratio), .n_val(n_val), .a_val(a_val), .cfg_err(cfg_err)
);

// File: tb/sl_top_tb.sv
module sl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic        psc_sel, cfg_err;
  logic [13:0] ref_ratio;
  logic [10:0] n_val;
  logic [6:0]  a_val;

  int total = 0, bad = 0;
  logic        e_psc = 1'b0, e_err = 1'b0;
  int          e_r = 8, e_n = 16, e_a = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sl_top dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .psc_sel(psc_sel), .ref_ratio(ref_ratio), .n_val(n_val), .a_val(a_val),
    .cfg_err(cfg_err)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " ref_ratio"}, int'(ref_ratio), e_r);
    chk({tag, " n_val"},     int'(n_val),     e_n);
    chk({tag, " a_val"},     int'(a_val),     e_a);
    chk({tag, " psc_sel"},   int'(psc_sel),   int'(e_psc));
    chk({tag, " cfg_err"},   int'(cfg_err),   int'(e_err));
  endtask

  // R2: MSB first, one bit per ser_clk rising edge
  task automatic shift_bits(input logic [21:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_cyc(HOLD);
      ser_clk = 1'b1;
      wait_cyc(HOLD);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_le();
    wait_cyc(HOLD);
    ser_le = 1'b1;
    wait_cyc(HOLD);
    ser_le = 1'b0;
    wait_cyc(8);
  endtask

  // R3 / R5 / R6 model
  task automatic load_ref(input logic p, input int r);
    shift_bits({6'd0, p, r[13:0], 1'b1}, 16);
    pulse_le();
    if (r >= 8) begin e_psc = p; e_r = r; e_err = 1'b0; end
    else e_err = 1'b1;
  endtask

  // R4 / R7 model
  task automatic load_main(input int n, input int a);
    shift_bits({3'd0, n[10:0], a[6:0], 1'b0}, 19);
    pulse_le();
    if (n >= 16) begin e_n = n; e_a = a; e_err = 1'b0; end
    else e_err = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(5);
    chk_all("R1 in reset");
    rst = 1'b0;
    wait_cyc(5);
    chk_all("R1 after reset");

    // R6 sweep across reference lower limit, mode alternating (R5)
    for (int r = 0; r <= 40; r++) begin
      load_ref(r[0], r);
      chk_all("R6 ref sweep");
    end
    // R3 walking ones through the reference ratio
    for (int b = 3; b < 14; b++) begin
      load_ref(b[1], 1 << b);
      chk_all("R3 ref walk");
    end
    load_ref(1'b1, 16383);
    chk_all("R3 ref max");
    load_ref(1'b0, 16383);
    chk_all("R5 mode 128/129");

    // R7 sweep across N lower limit with varying A
    for (int n = 0; n <= 40; n++) begin
      load_main(n, (n * 37) % 128);
      chk_all("R7 main sweep");
    end
    // R4 walking ones through N and A
    for (int b = 4; b < 11; b++) begin
      load_main(1 << b, 1 << (b - 4));
      chk_all("R4 main walk");
    end
    load_main(2047, 127);
    chk_all("R4 main max");

    // R8 error sticky across a second bad word, cleared by a good one
    load_ref(1'b1, 3);
    chk_all("R8 err set");
    load_main(5, 9);
    chk_all("R8 err still set");
    load_ref(1'b1, 100);
    chk_all("R8 err cleared");

    // R9: LE held high while another word is shifted in
    shift_bits({6'd0, 1'b0, 14'd500, 1'b1}, 16);
    wait_cyc(HOLD);
    ser_le = 1'b1;
    wait_cyc(8);
    e_psc = 1'b0; e_r = 500;
    chk_all("R9 first load");
    shift_bits({3'd0, 11'd99, 7'd3, 1'b0}, 19);
    wait_cyc(8);
    chk_all("R9 no reload while LE high");
    ser_le = 1'b0;
    wait_cyc(8);
    chk_all("R9 after LE low");

    // R10: shifting without a load strobe
    shift_bits({6'd0, 1'b1, 14'd9000, 1'b1}, 16);
    wait_cyc(8);
    chk_all("R10 no load");

    // R11: junk leading bits before a reference word
    shift_bits({3'b101, 3'b000, 1'b1, 14'd1234, 1'b1}, 19);
    pulse_le();
    e_psc = 1'b1; e_r = 1234; e_err = 1'b0;
    chk_all("R11 prefix ignored");
    shift_bits({3'b111, 11'd300, 7'd77, 1'b0}, 22);
    pulse_le();
    e_n = 300; e_a = 77;
    chk_all("R11 main prefix ignored");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule